// File: doc/BRIEF.md
# FIFO Contract Monitor

This block is a synthesizable observer placed next to a valid/ready FIFO. It watches every port of that FIFO and never drives any of them. It keeps its own occupancy count and a shadow copy of every accepted word. From these it judges each cycle of traffic against the FIFO contract. The contract covers the full and empty flags, the rule that links the valid output to the empty flag, the rule that governs the ready output, the handshakes that happen at the boundaries, and the order and value of every word that leaves the FIFO.

Each class of violation has its own error bit. An error bit is set one clock edge after the cycle in which the violation occurred. Once set, it stays set until reset. A combined output is high whenever any error bit is set. The monitor can stay attached in simulation or in silicon: it needs only the clock, the synchronous active-low reset and the observed FIFO ports.

Top module: `fifo_contract_monitor`

## Requirements
- R1: When `rst_n` is low at a clock edge, the tracked count and the shadow queue are emptied and `err_code` is set to 0. Any word held before the reset is never compared afterwards.
- R2: A legal pop is one where `mon_out_valid` and `mon_out_ready` are both high and the tracked count is non-zero. At each legal pop, `mon_out_data` must equal the oldest shadowed word. Otherwise `err_code[0]` is set.
- R3: `mon_out_data` is not compared in any cycle where `mon_out_valid` is low, whatever its value.
- R4: Once flag checks are armed, `err_code[1]` is set whenever `mon_full` differs from (tracked count == DEPTH).
- R5: Once flag checks are armed, `err_code[2]` is set whenever `mon_empty` differs from (tracked count == 0).
- R6: Once flag checks are armed, `err_code[3]` is set in any cycle where `mon_out_valid` equals `mon_empty`. This is a same-cycle check.
- R7: Once flag checks are armed, `err_code[4]` is set whenever `mon_in_ready` differs from (!`mon_full` || (`mon_out_valid` && `mon_out_ready`)).
- R8: A push is `mon_in_valid` && `mon_in_ready`. A push at tracked count DEPTH with no pop in the same cycle sets `err_code[5]`, and the word is not stored. A push at DEPTH together with a legal pop is accepted and stored.
- R9: A pop handshake at tracked count 0 sets `err_code[6]`. It leaves the count and the queue untouched.
- R10: The tracked count changes by +1 on a stored push alone and by -1 on a legal pop alone. It stays the same when both happen together. The shadow pointers wrap from DEPTH-1 to 0, so order holds across any number of wraps.
- R11: The checks of R4 to R7 are suppressed in the first cycle after `rst_n` returns high and are active from the second cycle on.
- R12: Every `err_code` bit is sticky until reset. `err_any` is high exactly when some `err_code` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the observed FIFO |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_in_valid | input | 1 | Observed write-side valid |
| mon_in_ready | input | 1 | Observed write-side ready |
| mon_in_data | input | WIDTH | Observed write data |
| mon_out_valid | input | 1 | Observed read-side valid |
| mon_out_ready | input | 1 | Observed read-side ready |
| mon_out_data | input | WIDTH | Observed read data |
| mon_full | input | 1 | Observed full flag |
| mon_empty | input | 1 | Observed empty flag |
| err_code | output | 7 | Sticky error bits, positions as in R2 and R4 to R9 |
| err_any | output | 1 | High when any error bit is set |

## Verification
The overflow rule and the data comparison can both apply in the same cycle. This happens when the FIFO is at DEPTH and a push and a pop arrive together. The bench provokes this case by filling the model FIFO to DEPTH and then asserting both handshakes at once. That cycle must raise no error, and the word that leaves must match the oldest stored word. The opposite case uses the same fill but forces ready high without a pop, and it must raise exactly the overflow and ready bits.

// File: rtl/fcm_pkg.sv
// Package: shared constants for the FIFO contract monitor.
// Assumes: error bit positions are fixed, because the bench and any
// downstream logging decode them.
package fcm_pkg;
    localparam int ERR_W     = 7;
    localparam int ERR_DATA  = 0;  // word differs from oldest shadowed word
    localparam int ERR_FULL  = 1;  // full flag disagrees with tracked count
    localparam int ERR_EMPTY = 2;  // empty flag disagrees with tracked count
    localparam int ERR_VALID = 3;  // valid output is not the inverse of empty
    localparam int ERR_READY = 4;  // ready output breaks its rule
    localparam int ERR_OVER  = 5;  // push at full without a pop
    localparam int ERR_UNDER = 6;  // pop while tracked count is zero

    typedef logic [ERR_W-1:0] err_vec_t;
endpackage

// File: rtl/fcm_occupancy.sv
// Module: occupancy tracker.
// Decides which observed handshakes are legal and keeps the count of
// stored words. Assumes push_req and pop_req are the raw handshakes seen
// on the FIFO ports. A push at full is legal only with a same-cycle pop.
module fcm_occupancy #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          overflow,
    output logic          underflow,
    output logic [CW-1:0] count,
    output logic          at_full,
    output logic          at_empty
);
    // Boundary decode of the tracked count.
    always_comb begin
        at_full  = (count == CW'(DEPTH));
        at_empty = (count == '0);
    end

    // Classify the observed handshakes as legal or as a violation.
    always_comb begin
        pop_ok    = pop_req && !at_empty;
        underflow = pop_req && at_empty;
        overflow  = push_req && at_full && !pop_req;
        push_ok   = push_req && !overflow;
    end

    // Count update: +1 on push alone, -1 on pop alone, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/fcm_shadow_queue.sv
// Module: shadow queue.
// Holds a copy of every accepted word in arrival order. Assumes the
// caller never writes when full unless it also reads in the same cycle.
// head_data is the oldest word and is meaningful only while non-empty.
module fcm_shadow_queue #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] head_data
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;

    // Pointer advance with an explicit wrap at the last slot.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer state: cleared by reset, advanced by each legal access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
        end
    end

    // Storage write; contents need no reset because the pointers gate reads.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // Oldest word, read before this edge's write lands.
    always_comb head_data = mem[rd_ptr];
endmodule

// File: rtl/fcm_error_regs.sv
// Module: sticky error register bank.
// Each bit latches high on its violation strobe and holds until reset.
// Assumes the strobes are already gated by any arming logic.
module fcm_error_regs #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    output logic [N-1:0] sticky,
    output logic         any
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One sticky flop per error class.
        always_ff @(posedge clk) begin
            if (!rst_n)     sticky[i] <= 1'b0;
            else if (hit[i]) sticky[i] <= 1'b1;
        end
    end

    // Summary of all classes.
    always_comb any = |sticky;
endmodule

// File: rtl/fifo_contract_monitor.sv
// Module: FIFO contract monitor (top).
// Observes a valid/ready FIFO and reports contract violations as sticky
// error bits. Assumes the observed FIFO shares clk and rst_n, and that
// WIDTH and DEPTH match that FIFO (DEPTH a power of two, at least 2).
module fifo_contract_monitor
    import fcm_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mon_in_valid,
    input  logic             mon_in_ready,
    input  logic [WIDTH-1:0] mon_in_data,
    input  logic             mon_out_valid,
    input  logic             mon_out_ready,
    input  logic [WIDTH-1:0] mon_out_data,
    input  logic             mon_full,
    input  logic             mon_empty,
    output logic [ERR_W-1:0] err_code,
    output logic             err_any
);
    logic          push_req, pop_req;
    logic          push_ok, pop_ok, overflow, underflow;
    logic          at_full, at_empty;
    logic [CW-1:0] occ_count;
    logic [WIDTH-1:0] head_data;
    logic          arm_q;
    err_vec_t      hit;

    // Raw handshakes as seen on the FIFO ports.
    always_comb begin
        push_req = mon_in_valid && mon_in_ready;
        pop_req  = mon_out_valid && mon_out_ready;
    end

    fcm_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .overflow  (overflow),
        .underflow (underflow),
        .count     (occ_count),
        .at_full   (at_full),
        .at_empty  (at_empty)
    );

    fcm_shadow_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_shq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (push_ok),
        .wr_data   (mon_in_data),
        .rd_en     (pop_ok),
        .head_data (head_data)
    );

    // Arming: flag checks wait one cycle after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= 1'b1;
    end

    // Per-class violation strobes for this cycle.
    always_comb begin
        hit            = '0;
        hit[ERR_DATA]  = pop_ok && (mon_out_data != head_data);
        hit[ERR_FULL]  = arm_q && (mon_full != at_full);
        hit[ERR_EMPTY] = arm_q && (mon_empty != at_empty);
        hit[ERR_VALID] = arm_q && (mon_out_valid == mon_empty);
        hit[ERR_READY] = arm_q && (mon_in_ready != (!mon_full || pop_req));
        hit[ERR_OVER]  = overflow;
        hit[ERR_UNDER] = underflow;
    end

    fcm_error_regs #(.N(ERR_W)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .sticky (err_code),
        .any    (err_any)
    );
endmodule

// File: rtl/fcm_checker.sv
// Module: assertion checker for the FIFO contract monitor.
// Bound into fifo_contract_monitor. It observes ports and internal
// tracker state and drives nothing.
module fcm_checker
    import fcm_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic [ERR_W-1:0] err_code,
    input logic [CW-1:0]    count,
    input logic             push_ok,
    input logic             pop_ok,
    input logic             overflow,
    input logic             underflow,
    input logic             arm
);
    // R1: the cycle after reset, all error bits are clear.
    p_reset_clears_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (err_code == '0));

    // R12: a set bit never clears without reset.
    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_code) |=> ((err_code & $past(err_code)) == $past(err_code)));

    // R10: the count never exceeds DEPTH.
    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R10: a stored push alone raises the count by one.
    p_push_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !pop_ok) |=> (count == $past(count) + 1'b1));

    // R10: a push and a pop together hold the count.
    p_push_pop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(count));

    // R8: an overflowing push leaves the count at DEPTH.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> (count == CW'(DEPTH)));

    // R9: a pop at zero with no push leaves the count at zero.
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !push_ok) |=> (count == '0));

    // R11: flag errors cannot appear from the unarmed cycle.
    p_flag_suppress_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (!err_code[ERR_FULL] && !err_code[ERR_EMPTY]));

    // R3: with valid low, no new data error appears.
    p_data_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !err_code[ERR_DATA]) |=> !err_code[ERR_DATA]);
endmodule

bind fifo_contract_monitor fcm_checker #(.DEPTH(DEPTH)) u_fcm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (mon_out_valid),
    .err_code  (err_code),
    .count     (occ_count),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .overflow  (overflow),
    .underflow (underflow),
    .arm       (arm_q)
);

// File: tb/fifo_contract_monitor_bench.sv
// Bench: drives the monitor from an ideal FIFO model, with optional
// corruption of single ports, and checks the sticky error vector.
module fifo_contract_monitor_bench;
    localparam int W = 8;
    localparam int D = 4;

    // Corruption kinds applied on top of the ideal model.
    localparam logic [3:0] C_NONE  = 4'd0;
    localparam logic [3:0] C_FULL  = 4'd1;  // invert full flag
    localparam logic [3:0] C_EMPTY = 4'd2;  // invert empty flag
    localparam logic [3:0] C_VALID = 4'd3;  // force valid low
    localparam logic [3:0] C_READY = 4'd4;  // invert ready
    localparam logic [3:0] C_DATA  = 4'd5;  // flip popped data
    localparam logic [3:0] C_JUNK  = 4'd6;  // junk data
    localparam logic [3:0] C_FORCE = 4'd7;  // force ready high
    localparam logic [3:0] C_UNDER = 4'd8;  // valid high, empty low at zero
    localparam logic [3:0] C_SWAP  = 4'd9;  // present second-oldest word

    typedef struct packed {
        logic [2:0] fill;
        logic       push;
        logic       pop;
        logic [3:0] cor;
        logic [6:0] exp;
    } row_t;

    localparam int NROW = 11;
    localparam row_t ROWS [NROW] = '{
        '{3'd0, 1'b1, 1'b0, C_NONE,  7'b0000000},  // R10 push alone
        '{3'd2, 1'b1, 1'b1, C_NONE,  7'b0000000},  // R10 push+pop mid
        '{3'd4, 1'b1, 1'b1, C_NONE,  7'b0000000},  // R8 push+pop at full
        '{3'd2, 1'b0, 1'b1, C_FULL,  7'b0000010},  // R4
        '{3'd2, 1'b0, 1'b0, C_EMPTY, 7'b0001100},  // R5 + R6
        '{3'd1, 1'b0, 1'b0, C_VALID, 7'b0001000},  // R6
        '{3'd1, 1'b0, 1'b0, C_READY, 7'b0010000},  // R7
        '{3'd2, 1'b0, 1'b1, C_DATA,  7'b0000001},  // R2
        '{3'd0, 1'b0, 1'b1, C_JUNK,  7'b0000000},  // R3
        '{3'd4, 1'b1, 1'b0, C_FORCE, 7'b0110000},  // R8 + R7
        '{3'd0, 1'b0, 1'b1, C_UNDER, 7'b1000100}   // R9 + R5
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iv = 1'b0, ir = 1'b0, ov = 1'b0, ordy = 1'b0, fl = 1'b0, em = 1'b1;
    logic [W-1:0] idata = '0, odata = '0;
    logic [6:0] err_code;
    logic err_any;

    logic [W-1:0] mq [$];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fifo_contract_monitor #(.WIDTH(W), .DEPTH(D)) u_fifo_contract_monitor (
        .clk           (clk),
        .rst_n         (rst_n),
        .mon_in_valid  (iv),
        .mon_in_ready  (ir),
        .mon_in_data   (idata),
        .mon_out_valid (ov),
        .mon_out_ready (ordy),
        .mon_out_data  (odata),
        .mon_full      (fl),
        .mon_empty     (em),
        .err_code      (err_code),
        .err_any       (err_any)
    );

    // One cycle of ideal-FIFO traffic with optional corruption.
    task automatic step(input logic push, input logic pop,
                        input logic [W-1:0] data, input logic [3:0] cor);
        logic tf, te;
        tf = (mq.size() == D);
        te = (mq.size() == 0);
        fl = tf; em = te; ov = !te; ordy = pop; iv = push; idata = data;
        odata = te ? 8'hEE : mq[0];
        case (cor)
            C_FULL:  fl = !tf;
            C_EMPTY: em = !te;
            C_VALID: ov = 1'b0;
            C_DATA:  odata = mq[0] ^ 8'hFF;
            C_JUNK:  odata = 8'h3C;
            C_UNDER: begin ov = 1'b1; em = 1'b0; end
            C_SWAP:  odata = mq[1];
            default: ;
        endcase
        ir = !tf || (ov && ordy);
        if (cor == C_READY) ir = !ir;
        if (cor == C_FORCE) ir = 1'b1;
        @(posedge clk);
        if (ov && ordy && mq.size() > 0) void'(mq.pop_front());
        if (iv && ir && mq.size() < D) mq.push_back(data);
        @(negedge clk);
    endtask

    task automatic do_reset(input bit idle_after);
        rst_n = 1'b0;
        mq.delete();
        step(1'b0, 1'b0, '0, C_NONE);
        step(1'b0, 1'b0, '0, C_NONE);
        rst_n = 1'b1;
        if (idle_after) step(1'b0, 1'b0, '0, C_NONE);
    endtask

    task automatic check(input string req, input logic [6:0] exp);
        n_checks++;
        if ({err_any, err_code} !== {|exp, exp}) begin
            n_fail++;
            $display("FAIL %s: err_any/err_code actual %b/%b expected %b/%b",
                     req, err_any, err_code, |exp, exp);
        end
    endtask

    initial begin
        @(negedge clk);
        // R1: clean state after reset
        do_reset(1'b1);
        check("R1 reset state", 7'b0);

        // Table walk: reset, fill, one stimulus cycle, check.
        for (int r = 0; r < NROW; r++) begin
            do_reset(1'b1);
            for (int k = 0; k < int'(ROWS[r].fill); k++)
                step(1'b1, 1'b0, W'(8'h10 + k), C_NONE);
            step(ROWS[r].push, ROWS[r].pop, 8'hA5, ROWS[r].cor);
            check($sformatf("table row %0d (R2-R10)", r), ROWS[r].exp);
        end

        // R11: the first cycle after release is unarmed, the second is armed.
        do_reset(1'b0);
        step(1'b0, 1'b0, '0, C_FULL);
        check("R11 unarmed cycle", 7'b0);
        step(1'b0, 1'b0, '0, C_FULL);
        check("R11 armed cycle", 7'b0010010);

        // R10 and R2: long mixed traffic that wraps the pointers.
        do_reset(1'b1);
        for (int k = 0; k < 40; k++)
            step((k % 3) != 2, (k % 2) == 1, W'(k * 7 + 1), C_NONE);
        check("R10 wrap traffic", 7'b0);
        while (mq.size() > 0) step(1'b0, 1'b1, '0, C_NONE);
        check("R10 drain after wrap", 7'b0);

        // R2: order swap is caught.
        step(1'b1, 1'b0, 8'h41, C_NONE);
        step(1'b1, 1'b0, 8'h42, C_NONE);
        step(1'b0, 1'b1, '0, C_SWAP);
        check("R2 order swap", 7'b0000001);

        // R12: the bit stays set through clean traffic.
        step(1'b1, 1'b0, 8'h50, C_NONE);
        step(1'b1, 1'b0, 8'h51, C_NONE);
        step(1'b0, 1'b0, '0, C_NONE);
        check("R12 sticky", 7'b0000001);

        // R1: reset mid-traffic discards stale words.
        do_reset(1'b1);
        check("R1 cleared after mid-traffic reset", 7'b0);
        step(1'b1, 1'b0, 8'h77, C_NONE);
        step(1'b0, 1'b1, '0, C_NONE);
        check("R1 fresh word after reset", 7'b0);

        // R9: a pop at zero alongside a push keeps the pushed word.
        do_reset(1'b1);
        step(1'b1, 1'b1, 8'h66, C_UNDER);
        step(1'b0, 1'b1, '0, C_NONE);
        check("R9 push kept during underflow", 7'b1000100);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule